// File: doc/BRIEF.md
# Staggered Dual-Slot Power-Up Sequencer

This block drives the power enables of two board slots that share one supply. When supply power comes up with both slots filled, the two boards must not draw inrush current at the same moment. Slot 0 is enabled first. Slot 1 follows after a programmable stagger delay, counted in whole seconds. The stagger applies only to a cold start with both slots ready together. A board that appears alone after power-up, a board inserted beside one that is already running, and a board that is pulled and pushed back in are all enabled at once.

Each slot reports presence with an active-low mated pin. That pin passes through a two-flop synchronizer and a debounce filter before the sequencer uses it. A prescaler divides the clock into one-second ticks. It restarts at the moment a stagger begins, so the wait is an exact number of ticks. Each slot's fan enable follows that slot's power enable. Dropping the supply-good input clears every decision, so the next power-up is again a cold start. All pins are plain level or strobe signals; the block has no streaming interface.

Top module: `pwrseq_stagger`

## Requirements
- R1: After reset, and one cycle after `ac_good_i` goes low, both power enables are 0 whatever the slots hold. The next rise of `ac_good_i` is treated as a cold start.
- R2: If both slots are present when the cold start is decided, slot 0 is enabled first. Slot 1 is enabled exactly D × CLK_PER_TICK cycles later, where D is the clamped stagger value held at that moment.
- R3: If only one slot is present at a cold start, that slot is enabled within the filter latency and without any stagger, whichever slot it is.
- R4: With one slot running, a board newly inserted into the other slot is enabled without stagger.
- R5: A running board that is removed and reinserted while the other keeps running is enabled again without stagger.
- R6: If supply power comes up with both slots empty and both boards are then inserted together, slot 1 still waits the stagger delay after slot 0.
- R7: A slot's power enable drops one cycle after its filtered presence goes away. Removing slot 1 during its stagger wait cancels the wait, and slot 1 stays off.
- R8: Each slot's fan enable equals that slot's power enable in every cycle.
- R9: The stagger value resets to 30. A value written with `cfg_load_i` is clamped to the range 1..60: 0 becomes 1, and anything above 60 becomes 60.
- R10: Writing a new stagger value while slot 1 is waiting does not change the wait already in progress.
- R11: A change on a mated pin that lasts less than DEB_CYCLES clock cycles has no effect on either power enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac_good_i | input | 1 | Shared supply is good (synchronous level) |
| mated_n_i | input | 2 | Per-slot presence, 0 = board fully mated (bit i is slot i) |
| cfg_load_i | input | 1 | One-cycle strobe that loads `cfg_delay_i` |
| cfg_delay_i | input | 6 | Requested stagger in seconds, clamped to 1..60 |
| pwr_en_o | output | 2 | Per-slot power enable (bit i is slot i) |
| fan_en_o | output | 2 | Per-slot fan enable (bit i is slot i) |

## Verification
Most internal faults show up at the power enables. If the cold-start flag is held wrongly, a late insertion is staggered when it should not be, or a dual cold start is not staggered at all. Either case appears at slot 1's enable within one filter latency of the insertion. A wrong delay load, clamp or prescaler restart shifts the rise of slot 1's enable by whole ticks. The bench catches this as a cycle-exact miscompare when that enable rises. A debounce fault lets a short glitch toggle an enable within a few cycles of the glitch.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int N_SLOTS = 2;

  // state of the slot that may be held back by the stagger
  typedef enum logic [1:0] {
    SLOT_OFF  = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_ON   = 2'd2
  } slot_state_e;

endpackage

// File: rtl/pwrseq_mate_filter.sv
module pwrseq_mate_filter #(
  parameter int DEB_CYCLES = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mated_n_i,
  output logic present_o
);
  localparam int CW = ($clog2(DEB_CYCLES) > 0) ? $clog2(DEB_CYCLES) : 1;

  logic [1:0]    sync_q;
  logic          raw_present;
  logic          stable_q;
  logic [CW-1:0] cnt_q;

  assign raw_present = ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync_q <= {sync_q[0], mated_n_i};
      if (raw_present == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
        stable_q <= raw_present;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign present_o = stable_q;
endmodule

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int CLK_PER_TICK = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = ($clog2(CLK_PER_TICK) > 0) ? $clog2(CLK_PER_TICK) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(CLK_PER_TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = at_end && !restart_i;
endmodule

// File: rtl/pwrseq_delay_cfg.sv
module pwrseq_delay_cfg #(
  parameter int DLY_MIN = 1,
  parameter int DLY_MAX = 60,
  parameter int DLY_DEF = 30,
  parameter int DLY_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] value_i,
  output logic [DLY_W-1:0] delay_o
);
  logic [DLY_W-1:0] clamped;
  logic [DLY_W-1:0] dly_q;

  always_comb begin
    if (value_i < DLY_W'(DLY_MIN))      clamped = DLY_W'(DLY_MIN);
    else if (value_i > DLY_W'(DLY_MAX)) clamped = DLY_W'(DLY_MAX);
    else                                clamped = value_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= DLY_W'(DLY_DEF);
    else if (load_i) dly_q <= clamped;
  end

  assign delay_o = dly_q;
endmodule

// File: rtl/pwrseq_core.sv
module pwrseq_core
  import pwrseq_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ac_good_i,
  input  logic [N_SLOTS-1:0] present_i,
  input  logic               tick_i,
  input  logic [DLY_W-1:0]   delay_i,
  output logic               restart_o,
  output logic               pending_o,
  output logic [N_SLOTS-1:0] pwr_en_o
);
  logic             en0_q, en0_d;
  slot_state_e      s1_q, s1_d;
  logic             cold_q, cold_d;
  logic [DLY_W-1:0] cnt_q;
  logic             start_stagger;
  logic             last_tick;

  // both slots ready together while nothing has run since supply came up
  assign start_stagger = ac_good_i && cold_q && present_i[0] && present_i[1]
                         && !en0_q && (s1_q == SLOT_OFF);
  assign last_tick     = tick_i && (cnt_q == DLY_W'(1));

  always_comb begin
    en0_d = ac_good_i && present_i[0];
    s1_d  = s1_q;
    if (!ac_good_i) begin
      s1_d = SLOT_OFF;
    end else begin
      unique case (s1_q)
        SLOT_OFF: begin
          if (!present_i[1])     s1_d = SLOT_OFF;
          else if (start_stagger) s1_d = SLOT_WAIT;
          else                    s1_d = SLOT_ON;
        end
        SLOT_WAIT: begin
          if (!present_i[1])  s1_d = SLOT_OFF;
          else if (last_tick) s1_d = SLOT_ON;
        end
        SLOT_ON: begin
          if (!present_i[1]) s1_d = SLOT_OFF;
        end
        default: s1_d = SLOT_OFF;
      endcase
    end
    if (!ac_good_i) cold_d = 1'b1;
    else            cold_d = cold_q && !en0_d && (s1_d == SLOT_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0_q  <= 1'b0;
      s1_q   <= SLOT_OFF;
      cold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      en0_q  <= en0_d;
      s1_q   <= s1_d;
      cold_q <= cold_d;
      if (start_stagger)                     cnt_q <= delay_i;
      else if (s1_q == SLOT_WAIT && tick_i)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign restart_o = start_stagger;
  assign pending_o = (s1_q == SLOT_WAIT);
  assign pwr_en_o  = {(s1_q == SLOT_ON), en0_q};
endmodule

// File: rtl/pwrseq_stagger.sv
module pwrseq_stagger
  import pwrseq_pkg::*;
#(
  parameter int CLK_PER_TICK = 50_000_000,
  parameter int DEB_CYCLES   = 200_000,
  parameter int DLY_MIN      = 1,
  parameter int DLY_MAX      = 60,
  parameter int DLY_DEF      = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ac_good_i,
  input  logic [1:0] mated_n_i,
  input  logic       cfg_load_i,
  input  logic [5:0] cfg_delay_i,
  output logic [1:0] pwr_en_o,
  output logic [1:0] fan_en_o
);
  localparam int DLY_W = 6;

  logic [N_SLOTS-1:0] pres_f;
  logic               tick;
  logic               restart;
  logic               pend;
  logic [DLY_W-1:0]   dly_q;
  logic [N_SLOTS-1:0] en;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    pwrseq_mate_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .mated_n_i (mated_n_i[g]),
      .present_o (pres_f[g])
    );
  end

  pwrseq_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .tick_o    (tick)
  );

  pwrseq_delay_cfg #(
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX),
    .DLY_DEF (DLY_DEF),
    .DLY_W   (DLY_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cfg_load_i),
    .value_i (cfg_delay_i),
    .delay_o (dly_q)
  );

  pwrseq_core #(.DLY_W(DLY_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ac_good_i (ac_good_i),
    .present_i (pres_f),
    .tick_i    (tick),
    .delay_i   (dly_q),
    .restart_o (restart),
    .pending_o (pend),
    .pwr_en_o  (en)
  );

  assign pwr_en_o = en;
  assign fan_en_o = en;
endmodule

// File: rtl/pwrseq_stagger_chk.sv
module pwrseq_stagger_chk #(
  parameter int DLY_MIN = 1,
  parameter int DLY_MAX = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ac_good_i,
  input logic [1:0] pres_f,
  input logic       pend,
  input logic [5:0] dly_q,
  input logic [1:0] pwr_en_o
);
  assert_ac_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_good_i |=> (pwr_en_o == 2'b00));

  assert_stagger_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($rose(pwr_en_o[0]) && !pwr_en_o[1]));

  assert_remove0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_f[0] |=> !pwr_en_o[0]);

  assert_remove1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_f[1] |=> !pwr_en_o[1]);

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pres_f[1]) |=> (!pend && !pwr_en_o[1]));

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q >= 6'(DLY_MIN)) && (dly_q <= 6'(DLY_MAX)));
endmodule

bind pwrseq_stagger pwrseq_stagger_chk #(.DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ac_good_i (ac_good_i),
  .pres_f    (pres_f),
  .pend      (pend),
  .dly_q     (dly_q),
  .pwr_en_o  (pwr_en_o)
);

// File: tb/sim_pwrseq_stagger.sv
module sim_pwrseq_stagger;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 8;
  localparam int DEB        = 4;
  localparam int IMM        = DEB + 5;
  localparam int WATCHDOG   = 150_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ac_good_i = 1'b0;
  logic [1:0] mated_n_i = 2'b11;
  logic       cfg_load_i = 1'b0;
  logic [5:0] cfg_delay_i = '0;
  logic [1:0] pwr_en_o;
  logic [1:0] fan_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrseq_stagger #(
    .CLK_PER_TICK (TICK),
    .DEB_CYCLES   (DEB)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ac_good_i   (ac_good_i),
    .mated_n_i   (mated_n_i),
    .cfg_load_i  (cfg_load_i),
    .cfg_delay_i (cfg_delay_i),
    .pwr_en_o    (pwr_en_o),
    .fan_en_o    (fan_en_o)
  );

  function automatic int clampd(input int v);
    if (v < 1)  return 1;
    if (v > 60) return 60;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: fan enable mirrors power enable on every sampled cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (fan_en_o != pwr_en_o) begin
        fails++;
        $display("FAIL R8 actual=%0d expected=%0d", fan_en_o, pwr_en_o);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(input int slot, input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (pwr_en_o[slot]) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic wait_fall(input int slot, input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (!pwr_en_o[slot]) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic load_cfg(input int v);
    cfg_delay_i = 6'(v);
    cfg_load_i  = 1'b1;
    @(negedge clk);
    cfg_load_i  = 1'b0;
  endtask

  task automatic supply_off();
    ac_good_i = 1'b0;
    @(negedge clk);
    check(pwr_en_o == 2'b00, "R1", pwr_en_o, 0);
  endtask

  // supply comes up with both boards in; checks the stagger distance
  task automatic staggered_start(input int exp_cycles, input string req);
    int n0;
    int n1;
    mated_n_i = 2'b00;
    cycles(IMM);
    ac_good_i = 1'b1;
    wait_rise(0, 4, n0);
    check(n0 > 0, req, n0, 1);
    check(pwr_en_o[1] == 1'b0, req, pwr_en_o[1], 0);
    wait_rise(1, exp_cycles + 20, n1);
    check(n1 == exp_cycles, req, n1, exp_cycles);
  endtask

  initial begin
    int n;
    int v;
    void'($urandom(32'd20240611));
    cycles(4);
    check(pwr_en_o == 2'b00, "R1", pwr_en_o, 0);
    check(fan_en_o == 2'b00, "R8", fan_en_o, 0);
    rst_n = 1'b1;
    // boards present but supply off: nothing may turn on
    mated_n_i = 2'b00;
    cycles(IMM + 4);
    check(pwr_en_o == 2'b00, "R1", pwr_en_o, 0);

    // R2 and R9: default delay of 30 ticks
    staggered_start(30 * TICK, "R2");

    // R5: pull and reinsert slot 1, then slot 0
    mated_n_i[1] = 1'b1;
    wait_fall(1, IMM, n);
    check(n > 0, "R7", n, 1);
    check(pwr_en_o[0] == 1'b1, "R5", pwr_en_o[0], 1);
    mated_n_i[1] = 1'b0;
    wait_rise(1, IMM, n);
    check(n > 0, "R5", n, 1);
    mated_n_i[0] = 1'b1;
    wait_fall(0, IMM, n);
    check(n > 0, "R7", n, 1);
    mated_n_i[0] = 1'b0;
    wait_rise(0, IMM, n);
    check(n > 0, "R5", n, 1);

    // R11: short glitches on both mated pins
    mated_n_i[0] = 1'b1;
    cycles(DEB - 2);
    mated_n_i[0] = 1'b0;
    cycles(IMM + 4);
    check(pwr_en_o == 2'b11, "R11", pwr_en_o, 3);

    // R1 then R3: slot 1 alone at a cold start, then R4 insert slot 0
    supply_off();
    mated_n_i = 2'b01;
    cycles(IMM + 2);
    check(pwr_en_o == 2'b00, "R1", pwr_en_o, 0);
    ac_good_i = 1'b1;
    wait_rise(1, 4, n);
    check(n > 0, "R3", n, 1);
    check(pwr_en_o[0] == 1'b0, "R3", pwr_en_o[0], 0);
    mated_n_i[0] = 1'b0;
    wait_rise(0, IMM, n);
    check(n > 0, "R4", n, 1);

    // R3 slot 0 alone, R4 insert slot 1 without stagger, R11 glitch on empty slot
    supply_off();
    mated_n_i = 2'b10;
    cycles(IMM + 2);
    ac_good_i = 1'b1;
    wait_rise(0, 4, n);
    check(n > 0, "R3", n, 1);
    mated_n_i[1] = 1'b0;
    cycles(DEB - 2);
    mated_n_i[1] = 1'b1;
    cycles(IMM + 4);
    check(pwr_en_o[1] == 1'b0, "R11", pwr_en_o[1], 0);
    mated_n_i[1] = 1'b0;
    wait_rise(1, IMM, n);
    check(n > 0, "R4", n, 1);

    // R6: supply up with empty slots, both inserted later together
    supply_off();
    mated_n_i = 2'b11;
    cycles(IMM + 2);
    ac_good_i = 1'b1;
    cycles(20);
    check(pwr_en_o == 2'b00, "R6", pwr_en_o, 0);
    mated_n_i = 2'b00;
    wait_rise(0, IMM, n);
    check(n > 0, "R6", n, 1);
    check(pwr_en_o[1] == 1'b0, "R6", pwr_en_o[1], 0);
    wait_rise(1, 30 * TICK + 20, n);
    check(n == 30 * TICK, "R6", n, 30 * TICK);

    // R9: directed clamp corners, then random values
    for (int k = 0; k < 12; k++) begin
      case (k)
        0: v = 0;
        1: v = 61;
        2: v = 63;
        3: v = 1;
        4: v = 60;
        default: v = int'($urandom_range(0, 63));
      endcase
      supply_off();
      load_cfg(v);
      staggered_start(clampd(v) * TICK, "R9");
    end

    // R10: new value written during the wait leaves that wait unchanged
    supply_off();
    load_cfg(30);
    mated_n_i = 2'b00;
    cycles(IMM);
    ac_good_i = 1'b1;
    wait_rise(0, 4, n);
    check(n > 0, "R10", n, 1);
    load_cfg(5);
    wait_rise(1, 30 * TICK + 20, n);
    check(n == 30 * TICK - 1, "R10", n, 30 * TICK - 1);

    // R7: removing slot 1 mid-wait cancels it; later reinsert is immediate
    supply_off();
    load_cfg(30);
    mated_n_i = 2'b00;
    cycles(IMM);
    ac_good_i = 1'b1;
    wait_rise(0, 4, n);
    check(n > 0, "R7", n, 1);
    cycles(50);
    mated_n_i[1] = 1'b1;
    wait_rise(1, 30 * TICK + 20, n);
    check(n == -1, "R7", n, -1);
    mated_n_i[1] = 1'b0;
    wait_rise(1, IMM, n);
    check(n > 0, "R4", n, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule